// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Sequencer

This block loads a configuration image into a downstream FPGA over a passive serial link. A one-cycle start request makes it run a timed handshake with the target. The target answers on two inputs: an active-low status line and a configuration-done line. The block then takes the image as a byte stream with a valid/ready handshake and a last marker. It packs the bytes into 32-bit words and shifts them out least significant bit first, with the serial clock idling low. It shifts a zero word at the end of the stream where one is needed, then waits for the target to report completion.

The sequence runs in fixed order through these states.
- `ST_IDLE`: the configuration-request output is high. `start_i` moves the block to `ST_REQ`.
- `ST_REQ`: the request output is low. The block waits for both synchronized lines to read low. On that acknowledge it goes to `ST_ARM`; on timeout it returns to `ST_IDLE` with an error.
- `ST_ARM`: the request output is high again. The block waits for the status line to rise. When it rises the block goes to `ST_SETUP`; on timeout it returns to `ST_IDLE` with an error.
- `ST_SETUP`: a fixed setup wait, then `ST_COLLECT`.
- `ST_COLLECT`: the byte input is ready. When a word is complete, or the last byte arrives, the block goes to `ST_SHIFT`.
- `ST_SHIFT`: the word is shifted out. After it, the block goes back to `ST_COLLECT` for more data. After the final word, it either shifts a zero word and stays in `ST_SHIFT`, or goes to `ST_FINISH`.
- `ST_FINISH`: the block waits for both lines high. On success it returns to `ST_IDLE` with `ok_o` set; on timeout it returns with an error.

Every delay and timeout is counted in system clock cycles. Each is worked out from the `CLK_HZ` parameter and a time given in microseconds. The serial clock half-period is `SCK_HALF` system cycles. Both target inputs pass through a two-flop synchronizer before any state uses them.

Top module: `ps_cfg_seq`

## Requirements
- R1: After reset and in `ST_IDLE`:
  - `cfg_n_o` is 1.
  - `busy_o`, `s_ready_o` and `sck_o` are 0.
  - `ok_o` and `err_o` are 0 after reset.
- R2: `start_i` in idle drives `cfg_n_o` low and `busy_o` high on the next cycle. Both synchronized inputs must then read low within ACK_US microseconds. Otherwise the block returns to idle with `err_o`=1 and `err_code_o` = {2'b01, done_i still high, stat_n_i still high}, that is bit1 for done and bit0 for status.
- R3: After the acknowledge, `cfg_n_o` returns high and `s_ready_o` stays 0. The status input must rise within START_US microseconds. Otherwise the block ends with `err_code_o` = 4'b1001.
- R4: At least SETUP_US microseconds pass between the rise of `stat_n_i` and the first rising edge of `sck_o`. `sck_o` toggles only while a word is being shifted.
- R5: Each word is shifted as 32 bits, least significant bit first. `sck_o` idles low, and `sdo_o` changes only while `sck_o` is low. Each half-period lasts SCK_HALF system cycles. The default (125 MHz, SCK_HALF=7) gives about 8.9 MHz, under the 10 MHz limit.
- R6: Bytes go into a word in arrival order, with the first byte in bits 7:0 and the fourth in bits 31:24. `s_ready_o` is high only in `ST_COLLECT`, never while a word is shifting.
- R7: A stream that ends on a partial word has its missing upper bytes sent as zeros. No further word follows it.
- R8: A stream whose length is a multiple of four bytes is followed by exactly one all-zero word.
- R9: After the data, both inputs must read high within DONE_US microseconds, and `ok_o` is then set. Otherwise `err_code_o` = {2'b11, done_i still low, stat_n_i still low}. `ok_o` and `err_o` are never both high.
- R10: `ok_o`, `err_o` and `err_code_o` hold until the next accepted start. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a configuration run (taken in idle only) |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the last of the image |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| cfg_n_o | output | 1 | Active-low configuration request to the target |
| stat_n_i | input | 1 | Target status line, low during reset or on error |
| done_i | input | 1 | Target configuration-done line |
| sck_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, valid on the rising edge of sck_o |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Last run completed successfully |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 4 | Phase in bits 3:2 and line flags in bits 1:0 |

## Verification
The bench builds the block with CLK_HZ = 8 MHz, START_US = 100, DONE_US = 200 and SCK_HALF = 1. ACK_US and SETUP_US keep their defaults of 2 µs, which is 16 cycles each. With these values every timeout path fits in a short run: the start phase expires after 800 cycles and the completion phase after 1600. The serial clock toggles every cycle, so the exact spacing of its edges can be checked. The 16-cycle setup count can be measured against the rise of the status line. Each timeout path and each line flag is driven, along with stream lengths of 1, 4, 5, 6 and 8 bytes, covering both the padding and the trailing-word endings.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ARM,
        ST_SETUP,
        ST_COLLECT,
        ST_SHIFT,
        ST_FINISH
    } ps_state_e;

    localparam logic [1:0] PH_ACK    = 2'b01;
    localparam logic [1:0] PH_START  = 2'b10;
    localparam logic [1:0] PH_FINISH = 2'b11;

    // microseconds to system clock cycles, never less than one cycle
    function automatic int us_to_cyc(input int hz, input int us);
        int c;
        c = (hz / 1_000_000) * us;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/ps_shifter.sv
module ps_shifter #(
    parameter int W    = 32,
    parameter int HALF = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         sck_o,
    output logic         sdo_o,
    output logic         active_o,
    output logic         done_o
);

    localparam int DIV_W = (HALF < 2) ? 1 : $clog2(HALF);
    localparam int BIT_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;
    logic             sck_q;
    logic             act_q;
    logic             tick;

    assign tick   = act_q && (div_q == DIV_W'(HALF - 1));
    assign done_o = tick && sck_q && (bit_q == BIT_W'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            div_q <= '0;
            bit_q <= '0;
            sck_q <= 1'b0;
            act_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= word_i;
            div_q <= '0;
            bit_q <= '0;
            sck_q <= 1'b0;
            act_q <= 1'b1;
        end else if (act_q) begin
            if (tick) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    sh_q  <= sh_q >> 1;
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == BIT_W'(W - 1)) begin
                        act_q <= 1'b0;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sck_o    = sck_q;
    assign sdo_o    = act_q & sh_q[0];
    assign active_o = act_q;

    // R5
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(sdo_o));

endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
    import ps_cfg_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int ACK_US   = 2,
    parameter int START_US = 1600,
    parameter int SETUP_US = 2,
    parameter int DONE_US  = 10_000,
    parameter int SCK_HALF = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  s_data_i,
    input  logic        s_valid_i,
    input  logic        s_last_i,
    output logic        s_ready_o,
    output logic        cfg_n_o,
    input  logic        stat_n_i,
    input  logic        done_i,
    output logic        sck_o,
    output logic        sdo_o,
    output logic        busy_o,
    output logic        ok_o,
    output logic        err_o,
    output logic [3:0]  err_code_o
);

    localparam int ACK_CYC   = us_to_cyc(CLK_HZ, ACK_US);
    localparam int START_CYC = us_to_cyc(CLK_HZ, START_US);
    localparam int SETUP_CYC = us_to_cyc(CLK_HZ, SETUP_US);
    localparam int DONE_CYC  = us_to_cyc(CLK_HZ, DONE_US);
    localparam int MAX_AB    = (ACK_CYC > START_CYC) ? ACK_CYC : START_CYC;
    localparam int MAX_CD    = (SETUP_CYC > DONE_CYC) ? SETUP_CYC : DONE_CYC;
    localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int BPW       = WORD_W / BYTE_W;
    localparam int IDX_W     = $clog2(BPW);

    ps_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q, word_merged, sh_word;
    logic              last_q, pad_q;
    logic              ok_q, err_q;
    logic [3:0]        code_q;
    logic              stat_lvl, done_lvl;
    logic              fire, word_end, sh_load, sh_active, sh_done;
    logic              ack_seen, ack_to, start_to, setup_end, fin_seen, fin_to;

    ps_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({stat_n_i, done_i}),
        .q_o   ({stat_lvl, done_lvl})
    );

    ps_shifter #(.W(WORD_W), .HALF(SCK_HALF)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (sh_load),
        .word_i   (sh_word),
        .sck_o    (sck_o),
        .sdo_o    (sdo_o),
        .active_o (sh_active),
        .done_o   (sh_done)
    );

    assign fire      = s_ready_o && s_valid_i;
    assign word_end  = (idx_q == IDX_W'(BPW - 1)) || s_last_i;
    assign ack_seen  = !stat_lvl && !done_lvl;
    assign ack_to    = (cnt_q == CNT_W'(ACK_CYC - 1));
    assign start_to  = (cnt_q == CNT_W'(START_CYC - 1));
    assign setup_end = (cnt_q == CNT_W'(SETUP_CYC - 1));
    assign fin_seen  = stat_lvl && done_lvl;
    assign fin_to    = (cnt_q == CNT_W'(DONE_CYC - 1));

    always_comb begin
        word_merged = word_q;
        word_merged[idx_q*BYTE_W +: BYTE_W] = s_data_i;
    end

    always_comb begin
        sh_load = 1'b0;
        sh_word = word_merged;
        if (state_q == ST_COLLECT && fire && word_end) begin
            sh_load = 1'b1;
        end else if (state_q == ST_SHIFT && sh_done && last_q && !pad_q) begin
            sh_load = 1'b1;
            sh_word = '0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_REQ;
            ST_REQ:     if (ack_seen) state_d = ST_ARM;
                        else if (ack_to) state_d = ST_IDLE;
            ST_ARM:     if (stat_lvl) state_d = ST_SETUP;
                        else if (start_to) state_d = ST_IDLE;
            ST_SETUP:   if (setup_end) state_d = ST_COLLECT;
            ST_COLLECT: if (fire && word_end) state_d = ST_SHIFT;
            ST_SHIFT:   if (sh_done) begin
                            if (!last_q)     state_d = ST_COLLECT;
                            else if (!pad_q) state_d = ST_SHIFT;
                            else             state_d = ST_FINISH;
                        end
            ST_FINISH:  if (fin_seen || fin_to) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
            last_q <= 1'b0;
            pad_q  <= 1'b0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
            code_q <= '0;
        end else begin
            if (state_d != state_q || state_q == ST_IDLE ||
                state_q == ST_COLLECT || state_q == ST_SHIFT) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    ok_q   <= 1'b0;
                    err_q  <= 1'b0;
                    code_q <= '0;
                    idx_q  <= '0;
                    word_q <= '0;
                    last_q <= 1'b0;
                    pad_q  <= 1'b0;
                end
                ST_REQ: if (!ack_seen && ack_to) begin
                    err_q  <= 1'b1;
                    code_q <= {PH_ACK, done_lvl, stat_lvl};
                end
                ST_ARM: if (!stat_lvl && start_to) begin
                    err_q  <= 1'b1;
                    code_q <= {PH_START, 2'b01};
                end
                ST_COLLECT: if (fire) begin
                    if (word_end) begin
                        word_q <= '0;
                        idx_q  <= '0;
                        last_q <= s_last_i;
                        pad_q  <= (idx_q != IDX_W'(BPW - 1));
                    end else begin
                        word_q <= word_merged;
                        idx_q  <= idx_q + 1'b1;
                    end
                end
                ST_SHIFT: if (sh_done && last_q && !pad_q) begin
                    pad_q <= 1'b1;
                end
                ST_FINISH: begin
                    if (fin_seen) begin
                        ok_q <= 1'b1;
                    end else if (fin_to) begin
                        err_q  <= 1'b1;
                        code_q <= {PH_FINISH, !done_lvl, !stat_lvl};
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cfg_n_o    = (state_q != ST_REQ);
        busy_o     = (state_q != ST_IDLE);
        s_ready_o  = (state_q == ST_COLLECT);
        ok_o       = ok_q;
        err_o      = err_q;
        err_code_o = code_q;
    end

    // R6
    ready_not_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !sh_active);

    // R4
    sck_in_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> (state_q == ST_SHIFT));

    // R9
    result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> !err_o);

    // R2
    req_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_n_o) |-> $past(start_i));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_code_o));

endmodule

// File: tb/ps_cfg_seq_tb_top.sv
module ps_cfg_seq_tb_top;

    localparam int CLK_HZ    = 8_000_000;
    localparam int SCK_HALF  = 1;
    localparam int SETUP_CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] s_data_i = '0;
    logic       s_valid_i = 1'b0;
    logic       s_last_i = 1'b0;
    logic       stat_n_i = 1'b1;
    logic       done_i = 1'b1;
    logic       s_ready_o, cfg_n_o, sck_o, sdo_o, busy_o, ok_o, err_o;
    logic [3:0] err_code_o;

    always #4 clk = ~clk;

    ps_cfg_seq #(
        .CLK_HZ(CLK_HZ), .ACK_US(2), .START_US(100), .SETUP_US(2),
        .DONE_US(200), .SCK_HALF(SCK_HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_data_i(s_data_i),
        .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
        .cfg_n_o(cfg_n_o), .stat_n_i(stat_n_i), .done_i(done_i),
        .sck_o(sck_o), .sdo_o(sdo_o), .busy_o(busy_o), .ok_o(ok_o),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    logic [31:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] base, input int k);
        return base + 8'(k * 37);
    endfunction

    // driver side of the scoreboard: expected words on the serial line
    task automatic push_words(input int n, input logic [7:0] base);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word;
            word = '0;
            for (int b = 0; b < 4; b++) begin
                if (w * 4 + b < n) word[8*b +: 8] = pat(base, w * 4 + b);
            end
            exp_q.push_back(word);
        end
        if (n % 4 == 0) exp_q.push_back(32'h0);
    endtask

    // monitor: rebuild words from the serial line and compare
    logic        prev_sck = 1'b0;
    logic [31:0] cap = '0;
    int          nbits = 0;
    longint      t_rise = 0;
    longint      t_stat = 0;
    bit          first_edge = 0;
    bit          word_bad = 0;

    always @(negedge clk) begin
        if (sck_o && !prev_sck) begin
            if (first_edge) begin
                first_edge = 0;
                check_eq("R4", "setup cycles met", 32'(cyc - t_stat >= SETUP_CYC), 1);
            end
            if (nbits > 0 && (cyc - t_rise) != 2 * SCK_HALF) word_bad = 1;
            if (s_ready_o) word_bad = 1;
            t_rise = cyc;
            cap = {sdo_o, cap[31:1]};
            nbits++;
            if (nbits == 32) begin
                nbits = 0;
                if (exp_q.size() == 0) begin
                    check_eq("R8", "unexpected extra word", cap, 32'hxxxx_xxxx);
                end else begin
                    check_eq("R5 R6 R7 R8", "serial word", cap, exp_q.pop_front());
                end
                check_eq("R5 R6", "edge spacing and ready during shift", 32'(word_bad), 0);
                word_bad = 0;
            end
        end
        prev_sck = sck_o;
    end

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    // mode: 0 ok, 1 status stuck high, 2 done stuck high, 3 no status rise,
    //       4 done never rises, 5 both low at finish
    task automatic run_cfg(input int n, input logic [7:0] base, input int mode,
                           input bit poke);
        stat_n_i = 1'b1;
        done_i   = 1'b1;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check_eq("R2", "cfg_n low after start", 32'(cfg_n_o), 0);
        check_eq("R2", "busy after start", 32'(busy_o), 1);
        repeat (2) @(negedge clk);
        if (mode != 1) stat_n_i = 1'b0;
        if (mode != 2) done_i = 1'b0;
        if (mode == 1 || mode == 2) begin
            wait_idle();
            check_eq("R2", "ack error flag", 32'(err_o), 1);
            check_eq("R2", "ack error code", 32'(err_code_o), (mode == 1) ? 32'h5 : 32'h6);
            return;
        end
        while (!cfg_n_o) @(negedge clk);
        check_eq("R3", "ready low while arming", 32'(s_ready_o), 0);
        repeat (40) @(negedge clk);
        if (mode == 3) begin
            wait_idle();
            check_eq("R3", "start error code", 32'(err_code_o), 32'h9);
            return;
        end
        push_words(n, base);
        stat_n_i   = 1'b1;
        t_stat     = cyc;
        first_edge = 1;
        for (int k = 0; k < n; k++) begin
            s_data_i  = pat(base, k);
            s_valid_i = 1'b1;
            s_last_i  = (k == n - 1);
            while (!s_ready_o) @(negedge clk);
            @(negedge clk);
            if (poke && k == 1) begin
                s_valid_i = 1'b0;
                start_i = 1'b1;
                @(negedge clk) start_i = 1'b0;
                check_eq("R10", "start ignored while busy", 32'(cfg_n_o), 1);
            end
        end
        s_valid_i = 1'b0;
        s_last_i  = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (mode == 0) done_i = 1'b1;
        if (mode == 5) stat_n_i = 1'b0;
        wait_idle();
        check_eq("R8", "no words left over", 32'(exp_q.size()), 0);
        if (mode == 0) begin
            check_eq("R9", "success flag", 32'(ok_o), 1);
            check_eq("R9", "no error on success", 32'(err_o), 0);
            repeat (5) @(negedge clk);
            check_eq("R10", "success held", 32'(ok_o), 1);
        end else begin
            check_eq("R9", "finish error code", 32'(err_code_o), (mode == 4) ? 32'hE : 32'hF);
        end
        check_eq("R1", "cfg_n high in idle", 32'(cfg_n_o), 1);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check_eq("R1", "reset cfg_n", 32'(cfg_n_o), 1);
        check_eq("R1", "reset busy", 32'(busy_o), 0);
        check_eq("R1", "reset ready", 32'(s_ready_o), 0);
        check_eq("R1", "reset sck", 32'(sck_o), 0);
        check_eq("R1", "reset results", 32'({ok_o, err_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_cfg(8, 8'h11, 0, 1);   // R8 whole words, trailing zero word
        run_cfg(6, 8'h40, 0, 0);   // R7 partial word padded
        run_cfg(1, 8'hA5, 0, 0);   // R7 single byte
        run_cfg(4, 8'h3C, 0, 0);   // R8 one word plus trailing word
        run_cfg(5, 8'h77, 0, 0);   // R6 packing across words
        run_cfg(4, 8'h00, 1, 0);   // R2 status stays high
        run_cfg(4, 8'h00, 2, 0);   // R2 done stays high
        run_cfg(4, 8'h00, 3, 0);   // R3 no status rise
        run_cfg(3, 8'h5A, 4, 0);   // R9 done low
        run_cfg(4, 8'hC3, 5, 0);   // R9 both low
        summary();
        $finish;
    end

endmodule